// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block is the address generator placed in front of one port of a dual-port memory array. Every clock it picks one of four actions for its internal address register. It can take a new start address from the external address bus, step the current address up by one for a burst, return to the start address of the current burst, or keep its value. The registered address is the address the memory uses for the access in that cycle.

A separate start register keeps the address taken at the most recent load. A repeat command can then replay a burst without anyone presenting the address again. Loads and repeats take effect at the rising clock edge, and the new address is visible on the output right after that edge. The address space has `DEPTH` locations. Stepping past the last location returns to zero, and the wrap indicator is high for the one cycle in which the wrapped address is presented.

Top module: `burst_addr_gen`

## Requirements
- R1: When `load_i` is high and `repeat_i` is low at a rising edge, `int_addr_o` equals the `ext_addr_i` sampled at that edge.
- R2: When `count_i` is high and both `load_i` and `repeat_i` are low at a rising edge, `int_addr_o` becomes its previous value plus one, provided the previous value is below `DEPTH-1`.
- R3: When `repeat_i` is high at a rising edge, `int_addr_o` becomes the address captured by the most recent load that took effect, or zero if no load has taken effect since reset.
- R4: Commands are resolved with a fixed priority: repeat first, then load, then count, then hold. A lower-priority strobe that is asserted together with a higher one has no effect on the address.
- R5: When `load_i`, `count_i` and `repeat_i` are all low at a rising edge, `int_addr_o` keeps its value and `wrap_o` is low.
- R6: A count step taken from any address at or above `DEPTH-1` sets `int_addr_o` to zero and drives `wrap_o` high for exactly that one cycle. `wrap_o` is low after every other kind of edge.
- R7: The start register changes only on a load that takes effect. Count steps, repeats, and a load overridden by a simultaneous repeat leave it unchanged, so a later repeat still returns to the earlier start address.
- R8: A rising edge with `rst_i` high clears both the address and the start register to zero and clears `wrap_o`, whatever the other inputs are.
- R9: With `load_i` high in every cycle, `int_addr_o` follows `ext_addr_i` with one cycle of delay, for any address sequence and whatever the earlier counter value was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| ext_addr_i | input | $clog2(DEPTH) | External start address |
| load_i | input | 1 | Take `ext_addr_i` as the new address and start address |
| count_i | input | 1 | Step the address up by one |
| repeat_i | input | 1 | Return to the last loaded start address |
| int_addr_o | output | $clog2(DEPTH) | Registered internal address for the current access |
| wrap_o | output | 1 | High for one cycle after a step wrapped to zero |

## Verification
Directed sequences cover the basic cases one at a time: a load followed by a long count run, repeats placed after both advances and repeats, and a load-every-cycle stream of scattered addresses. These separate step-by-one behaviour from bypass behaviour. Conflicting strobes (repeat with load, load with count) show whether the priority and the start-register update rule are right. Bursts that start at `DEPTH-2` and at the top of the address field show where the wrap happens and whether the pulse lasts one cycle. A long random-strobe phase, checked every cycle against a behavioural model, exercises the command mixes that the directed cases do not reach.

// File: rtl/bag_pkg.sv
package bag_pkg;

    // Resolved per-cycle command of the address generator
    typedef enum logic [1:0] {
        CMD_HOLD   = 2'd0,
        CMD_STEP   = 2'd1,
        CMD_LOAD   = 2'd2,
        CMD_REPEAT = 2'd3
    } bag_cmd_e;

endpackage

// File: rtl/bag_cmd_decode.sv
module bag_cmd_decode
    import bag_pkg::*;
(
    input  logic     load_i,
    input  logic     count_i,
    input  logic     repeat_i,
    output bag_cmd_e cmd_o
);

    // Fixed priority: repeat, load, count, hold
    always_comb begin
        if (repeat_i)     cmd_o = CMD_REPEAT;
        else if (load_i)  cmd_o = CMD_LOAD;
        else if (count_i) cmd_o = CMD_STEP;
        else              cmd_o = CMD_HOLD;
    end

endmodule

// File: rtl/bag_step.sv
module bag_step #(
    parameter int DEPTH = 160,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] cur_i,
    output logic [AW-1:0] nxt_o,
    output logic          wrap_o
);

    localparam int LAST = DEPTH - 1;
    localparam bit POW2 = (DEPTH == (1 << AW));

    generate
        if (POW2) begin : g_pow2
            // Natural overflow of the adder marks the wrap
            always_comb begin
                {wrap_o, nxt_o} = {1'b0, cur_i} + {{AW{1'b0}}, 1'b1};
            end
        end else begin : g_cmp
            // Compare against the last legal location; anything above it wraps too
            always_comb begin
                wrap_o = (cur_i >= AW'(LAST));
                nxt_o  = wrap_o ? '0 : cur_i + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int DEPTH = 160,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [AW-1:0] ext_addr_i,
    input  logic          load_i,
    input  logic          count_i,
    input  logic          repeat_i,
    output logic [AW-1:0] int_addr_o,
    output logic          wrap_o
);

    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] start;
        logic          wrap;
    } gen_state_t;

    gen_state_t    st_d, st_q;
    bag_cmd_e      cmd;
    logic [AW-1:0] step_nxt;
    logic          step_wrap;

    bag_cmd_decode u_dec (
        .load_i   (load_i),
        .count_i  (count_i),
        .repeat_i (repeat_i),
        .cmd_o    (cmd)
    );

    bag_step #(.DEPTH(DEPTH)) u_step (
        .cur_i  (st_q.addr),
        .nxt_o  (step_nxt),
        .wrap_o (step_wrap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        unique case (cmd)
            CMD_REPEAT: st_d.addr = st_q.start;
            CMD_LOAD: begin
                st_d.addr  = ext_addr_i;
                st_d.start = ext_addr_i;
            end
            CMD_STEP: begin
                st_d.addr = step_nxt;
                st_d.wrap = step_wrap;
            end
            default: ;
        endcase
        if (rst_i) st_d = '0;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign int_addr_o = st_q.addr;
    assign wrap_o     = st_q.wrap;

    // R1
    load_take_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && !repeat_i) |=> (int_addr_o == $past(ext_addr_i)));

    // R2
    step_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_i && !load_i && !repeat_i && int_addr_o < AW'(LAST))
        |=> (int_addr_o == $past(int_addr_o) + 1'b1) && !wrap_o);

    // R3
    repeat_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        repeat_i |=> (int_addr_o == $past(st_q.start)));

    // R5
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !count_i && !repeat_i) |=> ($stable(int_addr_o) && !wrap_o));

    // R6
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |-> (int_addr_o == '0));

    // R6
    wrap_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wrap_o && !count_i) |=> !wrap_o);

    // R7
    start_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i || repeat_i) |=> $stable(st_q.start));

    // R8
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (int_addr_o == '0 && st_q.start == '0 && !wrap_o));

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    localparam int DEPTH = 160;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] ext;
    logic          ld, cnt, rpt;
    logic [AW-1:0] addr;
    logic          wrap;

    int checks = 0;
    int errors = 0;
    int m_addr, m_start;
    bit m_wrap;

    always #5 clk = ~clk;

    burst_addr_gen #(.DEPTH(DEPTH)) u0 (
        .clk_i(clk), .rst_i(rst), .ext_addr_i(ext),
        .load_i(ld), .count_i(cnt), .repeat_i(rpt),
        .int_addr_o(addr), .wrap_o(wrap)
    );

    // Behavioural reference, evaluated at each rising edge from stable inputs
    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_start = 0; m_wrap = 0;
        end else if (rpt) begin
            m_addr = m_start; m_wrap = 0;
        end else if (ld) begin
            m_addr = int'(ext); m_start = int'(ext); m_wrap = 0;
        end else if (cnt) begin
            if (m_addr >= DEPTH - 1) begin m_addr = 0; m_wrap = 1; end
            else begin m_addr = m_addr + 1; m_wrap = 0; end
        end else begin
            m_wrap = 0;
        end
    end

    task automatic check(input string tag);
        checks++;
        if (int'(addr) != m_addr || wrap != m_wrap) begin
            errors++;
            $display("FAIL %s: addr=%0d wrap=%0b expected addr=%0d wrap=%0b",
                     tag, addr, wrap, m_addr, m_wrap);
        end
    endtask

    task automatic cyc(input bit l, input bit c, input bit r, input int a, input string tag);
        ld = l; cnt = c; rpt = r; ext = AW'(a);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; ld = 1; cnt = 1; rpt = 0; ext = 8'd77;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset state");
        rst = 0;
        cyc(0, 0, 1, 5, "R8 repeat after reset gives zero");
        // R1 load, then R2 counting
        cyc(1, 0, 0, 20, "R1 load");
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 99, "R2 count step");
        cyc(0, 0, 0, 3, "R5 hold");
        cyc(0, 0, 0, 3, "R5 hold");
        // R3 / R7 repeat after advances and after repeats
        cyc(0, 0, 1, 0, "R3 repeat to start");
        cyc(0, 1, 0, 0, "R2 count after repeat");
        cyc(0, 0, 1, 0, "R7 repeat again");
        cyc(0, 0, 1, 0, "R7 repeat after repeat");
        // R4 priority cases
        cyc(1, 1, 1, 90, "R4 repeat over load");
        cyc(0, 1, 0, 0, "R4 step");
        cyc(0, 0, 1, 0, "R7 start unchanged by overridden load");
        cyc(1, 1, 0, 40, "R4 load over count");
        cyc(0, 0, 1, 0, "R3 repeat to new start");
        // R6 wrap at DEPTH-1
        cyc(1, 0, 0, DEPTH - 2, "R1 load near top");
        cyc(0, 1, 0, 0, "R2 step to last");
        cyc(0, 1, 0, 0, "R6 wrap to zero");
        cyc(0, 1, 0, 0, "R6 wrap pulse one cycle");
        cyc(1, 0, 0, 255, "R1 load above last");
        cyc(0, 1, 0, 0, "R6 wrap from above last");
        cyc(0, 0, 0, 0, "R6 hold clears wrap");
        cyc(1, 0, 0, DEPTH - 1, "R1 load last");
        cyc(0, 1, 0, 0, "R6 wrap from last");
        cyc(0, 0, 1, 0, "R6 repeat clears wrap");
        // R9 load every cycle with scattered addresses
        for (int i = 0; i < 12; i++) cyc(1, (i % 2) == 1, 0, (i * 37 + 11) % 256, "R9 load stream");
        // R8 reset in mid burst
        rst = 1; ld = 0; cnt = 1; rpt = 0;
        @(posedge clk); @(negedge clk);
        check("R8 reset mid burst");
        rst = 0;
        cyc(0, 0, 1, 0, "R8 start cleared");
        // Random mix against the model
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            bit l = (r < 20), c = ($urandom_range(0, 3) != 0), p = ($urandom_range(0, 9) == 0);
            int a = (i % 5 == 0) ? DEPTH - 2 : $urandom_range(0, 255);
            cyc(l, c, p, a, p ? "R3 random repeat" : (l ? "R1 random load" :
                (c ? "R2 random count" : "R5 random hold")));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule